// File: doc/BRIEF.md
# Binary-Field Inverter for GF(2^233)

This block returns the multiplicative inverse of a 233-bit element of the binary field defined by the trinomial f(z) = z^233 + z^74 + 1. It raises the operand to the power 2^233 − 2 through an addition chain that is steered by a halving counter. That chain needs eleven field products and 233 squarings. A single bit-serial multiplier and a one-step squarer, both inside the block, do all of the work. A small sequencer moves values through three working registers: the running power, the accumulated result, and a scratch copy that absorbs the repeated squarings.

A caller places the element on `operand` and pulses `start` while the block is idle. After a fixed number of cycles `done` pulses and `result` carries the inverse. A zero operand has no inverse. In that case the block finishes at once, raises `err`, and returns zero. `result` and `err` keep their values until the next completion.

Top module: `itoh_inv233`

## Requirements
- R1: For any nonzero operand a, the returned value r satisfies a·r = 1 in GF(2^233), where the modulus is z^233 + z^74 + 1 and bit i of a vector is the coefficient of z^i.
- R2: The operand 1 (only bit 0 set) returns 1.
- R3: A zero operand gives err = 1 and result = 0, and done is high in the cycle right after the rising edge that accepted start.
- R4: For a nonzero operand, done first goes high at the 2814th rising edge after the accepting edge. That figure is one initial squaring cycle plus, for each value x of the halving counter (116, 58, 29, 14, 7, 3, 1), x squaring cycles and one product of M+2 = 235 cycles, plus a second 235-cycle product for every odd x.
- R5: done is high for exactly one cycle per operation.
- R6: start is ignored while an operation is running. The running operation finishes with the same result and the same timing.
- R7: result and err change only in the cycle where done is high. Between completions they hold their previous values.
- R8: While reset is asserted (rst_n low, active-low, synchronous), done, err and result are all 0.
- R9: err is 0 on completion for every nonzero operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an inversion; honoured only when idle |
| operand | input | 233 | Field element to invert, sampled with start |
| result | output | 233 | Inverse, valid from the done pulse onward |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set on completion when the operand was zero |

## Verification
A zero operand completes in the cycle after the accepting edge. A nonzero operand completes at the 2814th rising edge after it. The bench works out that 2814 from the counter schedule in its own function and does not take it from the design. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the accepting edge until done is seen, and compares that count with the expected one. It reads result and err in that same sample and checks that done has fallen one cycle later. Hold behaviour is checked twice. It is probed fifty edges into a run, where the values must still be those of the previous completion. It is probed again a few idle cycles after a completion.

// File: rtl/itoh_pkg.sv
package itoh_pkg;

  // Default field: degree and middle exponent of the trinomial modulus
  localparam int unsigned FIELD_DEG = 233;
  localparam int unsigned FIELD_MID = 74;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_INIT    = 3'd1,
    ST_POW     = 3'd2,
    ST_MA_GO   = 3'd3,
    ST_MA_WAIT = 3'd4,
    ST_MB_GO   = 3'd5,
    ST_MB_WAIT = 3'd6
  } inv_state_t;

endpackage

// File: rtl/gf_squarer.sv
module gf_squarer #(
  parameter int unsigned M = itoh_pkg::FIELD_DEG,
  parameter int unsigned K = itoh_pkg::FIELD_MID
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);

  localparam int unsigned WW = 2*M - 1;

  // Spread the bits to even positions, then fold every term of degree >= M
  // back down using z^M = z^K + 1, walking from the top degree downward.
  function automatic logic [M-1:0] square_mod(input logic [M-1:0] v);
    logic [WW-1:0] w;
    w = '0;
    for (int i = 0; i < int'(M); i++) begin
      w[2*i] = v[i];
    end
    for (int i = int'(WW) - 1; i >= int'(M); i--) begin
      if (w[i]) begin
        w[i]         = 1'b0;
        w[i - M]     = ~w[i - M];
        w[i - M + K] = ~w[i - M + K];
      end
    end
    return w[M-1:0];
  endfunction

  assign y = square_mod(a);

endmodule

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
  parameter int unsigned M = itoh_pkg::FIELD_DEG,
  parameter int unsigned K = itoh_pkg::FIELD_MID
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         busy,
  output logic         rdy,
  output logic [M-1:0] prod
);

  localparam int unsigned CW = $clog2(M + 1);
  localparam logic [M-1:0] ONE_V    = {{(M-1){1'b0}}, 1'b1};
  localparam logic [M-1:0] RED_TAIL = (ONE_V << K) | ONE_V;

  // One step of the most-significant-bit-first product:
  // acc <- acc*z mod f, then add b if the scanned multiplier bit is set.
  function automatic logic [M-1:0] mac_step(input logic [M-1:0] acc,
                                            input logic         sel,
                                            input logic [M-1:0] bv);
    logic [M-1:0] s;
    s = {acc[M-2:0], 1'b0};
    if (acc[M-1]) s = s ^ RED_TAIL;
    if (sel)      s = s ^ bv;
    return s;
  endfunction

  logic [M-1:0]  acc_q;
  logic [M-1:0]  scan_q;
  logic [M-1:0]  mcand_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      scan_q  <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (go) begin
        acc_q   <= '0;
        scan_q  <= a;
        mcand_q <= b;
        cnt_q   <= CW'(M);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        acc_q  <= mac_step(acc_q, scan_q[M-1], mcand_q);
        scan_q <= {scan_q[M-2:0], 1'b0};
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          rdy_q  <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign rdy  = rdy_q;
  assign prod = acc_q;

endmodule

// File: rtl/itoh_seq.sv
module itoh_seq
  import itoh_pkg::*;
#(
  parameter int unsigned M  = itoh_pkg::FIELD_DEG,
  parameter int unsigned XW = $clog2(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] operand,
  input  logic [M-1:0] sq_a,
  input  logic [M-1:0] sq_t,
  input  logic         mul_rdy,
  input  logic [M-1:0] mul_prod,
  output logic [M-1:0] a_reg,
  output logic [M-1:0] t_reg,
  output logic         mul_go,
  output logic [M-1:0] mul_x,
  output logic [M-1:0] mul_y,
  output logic [M-1:0] result,
  output logic         done,
  output logic         err,
  output logic         busy,
  output logic         accept
);

  localparam logic [M-1:0]  ONE_V = {{(M-1){1'b0}}, 1'b1};
  localparam logic [XW-1:0] X0    = XW'((M - 1) / 2);

  inv_state_t    state_q;
  logic [M-1:0]  a_q, b_q, t_q, res_q;
  logic [XW-1:0] x_q, cnt_q;
  logic          done_q, err_q;
  logic [XW-1:0] x_half;

  assign x_half = x_q >> 1;
  assign accept = (state_q == ST_IDLE) && start;
  assign busy   = (state_q != ST_IDLE);
  assign mul_go = (state_q == ST_MA_GO) || (state_q == ST_MB_GO);
  assign mul_x  = (state_q == ST_MB_GO) ? b_q : a_q;
  assign mul_y  = (state_q == ST_MB_GO) ? a_q : t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      t_q     <= '0;
      res_q   <= '0;
      x_q     <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (operand == '0) begin
              res_q  <= '0;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              a_q     <= operand;
              b_q     <= ONE_V;
              x_q     <= X0;
              state_q <= ST_INIT;
            end
          end
        end
        ST_INIT: begin
          a_q     <= sq_a;
          t_q     <= sq_a;
          cnt_q   <= x_q;
          state_q <= ST_POW;
        end
        ST_POW: begin
          t_q   <= sq_t;
          cnt_q <= cnt_q - XW'(1);
          if (cnt_q == XW'(1)) state_q <= ST_MA_GO;
        end
        ST_MA_GO: state_q <= ST_MA_WAIT;
        ST_MA_WAIT: begin
          if (mul_rdy) begin
            a_q <= mul_prod;
            if (x_q[0]) begin
              state_q <= ST_MB_GO;
            end else begin
              t_q     <= mul_prod;
              x_q     <= x_half;
              cnt_q   <= x_half;
              state_q <= ST_POW;
            end
          end
        end
        ST_MB_GO: state_q <= ST_MB_WAIT;
        ST_MB_WAIT: begin
          if (mul_rdy) begin
            b_q   <= mul_prod;
            a_q   <= sq_a;
            t_q   <= sq_a;
            x_q   <= x_half;
            cnt_q <= x_half;
            if (x_half == '0) begin
              res_q   <= mul_prod;
              err_q   <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_POW;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign a_reg  = a_q;
  assign t_reg  = t_q;
  assign result = res_q;
  assign done   = done_q;
  assign err    = err_q;

endmodule

// File: rtl/itoh_inv233.sv
module itoh_inv233 #(
  parameter int unsigned M = itoh_pkg::FIELD_DEG,
  parameter int unsigned K = itoh_pkg::FIELD_MID
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] operand,
  output logic [M-1:0] result,
  output logic         done,
  output logic         err
);

  localparam int unsigned XW = $clog2(M);

  // Named internal events, visible to the bound checker
  logic         busy;
  logic         accept;
  logic         mul_go;
  logic         mul_busy;
  logic         mul_rdy;
  logic [M-1:0] mul_x, mul_y, mul_prod;
  logic [M-1:0] a_reg, t_reg, sq_a, sq_t;

  gf_squarer #(.M(M), .K(K)) u_sq_a (.a(a_reg), .y(sq_a));
  gf_squarer #(.M(M), .K(K)) u_sq_t (.a(t_reg), .y(sq_t));

  gf_serial_mul #(.M(M), .K(K)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (mul_go),
    .a    (mul_x),
    .b    (mul_y),
    .busy (mul_busy),
    .rdy  (mul_rdy),
    .prod (mul_prod)
  );

  itoh_seq #(.M(M), .XW(XW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .sq_a    (sq_a),
    .sq_t    (sq_t),
    .mul_rdy (mul_rdy),
    .mul_prod(mul_prod),
    .a_reg   (a_reg),
    .t_reg   (t_reg),
    .mul_go  (mul_go),
    .mul_x   (mul_x),
    .mul_y   (mul_y),
    .result  (result),
    .done    (done),
    .err     (err),
    .busy    (busy),
    .accept  (accept)
  );

endmodule

// File: rtl/itoh_inv233_chk.sv
module itoh_inv233_chk #(
  parameter int unsigned M = itoh_pkg::FIELD_DEG
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         err,
  input logic [M-1:0] result,
  input logic         busy,
  input logic         accept,
  input logic         mul_go,
  input logic         mul_busy
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_ZERO_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0)); // R3

  AST_NONZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (result != '0)); // R1

  AST_HOLD_BETWEEN_DONES: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(err))); // R7

  AST_MUL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy); // R4

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !done || $past(mul_busy) == 1'b0); // R6

  AST_NO_ACCEPT_MID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> !accept); // R6

endmodule

bind itoh_inv233 itoh_inv233_chk #(.M(M)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .done    (done),
  .err     (err),
  .result  (result),
  .busy    (busy),
  .accept  (accept),
  .mul_go  (mul_go),
  .mul_busy(mul_busy)
);

// File: tb/itoh_inv233_tb.sv
`timescale 1ns/1ps
module itoh_inv233_tb;

  localparam int M = 233;
  localparam int K = 74;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] operand = '0;
  logic [M-1:0] result;
  logic         done;
  logic         err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  itoh_inv233 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .result(result), .done(done), .err(err)
  );

  localparam logic [M-1:0] ONE_V = {{(M-1){1'b0}}, 1'b1};

  // Least-significant-bit-first reference product, reduction by z^M = z^K + 1
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, sh;
    logic top;
    acc = '0;
    sh  = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ sh;
      top = sh[M-1];
      sh  = sh << 1;
      if (top) begin
        sh[0] = ~sh[0];
        sh[K] = ~sh[K];
      end
    end
    return acc;
  endfunction

  // Completion latency from the counter schedule stated in R4
  function automatic int exp_latency();
    int lat, x;
    lat = 1;
    x = (M - 1) / 2;
    while (x != 0) begin
      lat += x + (M + 2);
      if (x % 2 == 1) begin
        lat += M + 2;
        x = (x - 1) / 2;
      end else begin
        x = x / 2;
      end
    end
    return lat;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Runs one inversion; optionally pulses start with a zero operand mid-run.
  task automatic run_inv(input logic [M-1:0] a, input bit inject,
                         output int lat, output logic [M-1:0] res, output logic e);
    logic [M-1:0] prev_res;
    logic prev_err;
    prev_res = result;
    prev_err = err;
    @(negedge clk);
    operand = a;
    start   = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 6000) begin
      if (lat == 50) begin
        check(result == prev_res, "R7", "result held mid-run", result, prev_res);
        check(err == prev_err, "R7", "err held mid-run", {{(M-1){1'b0}}, err}, {{(M-1){1'b0}}, prev_err});
      end
      if (inject && (lat == 100 || lat == 101)) begin
        start   = 1'b1;
        operand = '0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start = 1'b0;
    if (lat >= 6000) check(1'b0, "R4", "run watchdog expired", '0, '0);
    res = result;
    e   = err;
    @(negedge clk);
    check(!done, "R5", "done lasts one cycle", {{(M-1){1'b0}}, done}, '0);
  endtask

  task automatic run_nonzero(input logic [M-1:0] a, input bit inject, input string tag);
    int lat;
    logic [M-1:0] res;
    logic e;
    run_inv(a, inject, lat, res, e);
    check(ref_mul(a, res) == ONE_V, inject ? "R6" : "R1", {tag, " a*inv"}, ref_mul(a, res), ONE_V);
    check(e == 1'b0, "R9", {tag, " err clear"}, {{(M-1){1'b0}}, e}, '0);
    check(lat == exp_latency(), inject ? "R6" : "R4", {tag, " latency"}, M'(lat), M'(exp_latency()));
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] big;
    logic [M-1:0] r, res, held;
    logic e;
    int lat;
    void'($urandom(32'h0233_5EED));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8", "done in reset", {{(M-1){1'b0}}, done}, '0);
    check(err == 1'b0, "R8", "err in reset", {{(M-1){1'b0}}, err}, '0);
    check(result == '0, "R8", "result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: inverse of one
    run_inv(ONE_V, 1'b0, lat, res, e);
    check(res == ONE_V, "R2", "inverse of one", res, ONE_V);
    check(lat == exp_latency(), "R4", "latency for one", M'(lat), M'(exp_latency()));

    // R3: zero operand
    run_inv('0, 1'b0, lat, res, e);
    check(e == 1'b1, "R3", "err for zero", {{(M-1){1'b0}}, e}, ONE_V);
    check(res == '0, "R3", "result for zero", res, '0);
    check(lat == 0, "R3", "zero completes next cycle", M'(lat), '0);

    // Next run probes that err=1 and result=0 are held mid-run (R7)
    run_nonzero(ONE_V << 1, 1'b0, "z");

    // R7: hold after completion while idle
    held = result;
    repeat (5) @(negedge clk);
    check(result == held, "R7", "result held idle", result, held);
    check(err == 1'b0, "R7", "err held idle", {{(M-1){1'b0}}, err}, '0);

    run_nonzero({M{1'b1}}, 1'b0, "all ones");
    run_nonzero(ONE_V << (M-1), 1'b0, "top bit");
    run_nonzero((ONE_V << K) | ONE_V, 1'b0, "tail");

    // R6: start pulses during a run are ignored
    run_nonzero((ONE_V << 7) | (ONE_V << 200) | ONE_V, 1'b1, "ignored start");

    for (int n = 0; n < 10; n++) begin
      for (int w = 0; w < 8; w++) big[w*32 +: 32] = $urandom();
      r = big[M-1:0];
      if (r == '0) r = ONE_V;
      run_nonzero(r, 1'b0, "random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule